// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit works out the next instruction pointer for two relative branch forms. The first is an unconditional relative jump. The second is a counted loop branch that decrements a 32-bit count and branches while the count stays nonzero. Each request presents the following values in one cycle, together with a one-cycle `issue` strobe:

- the current instruction pointer;
- the length of the branch instruction;
- an 8-bit signed displacement;
- a kind code;
- the present count value.

One clock later the unit returns the new instruction pointer, the updated count and a taken flag, with `out_vld` high for that one cycle.

Every branch target is measured from the address of the instruction after the branch, that is, the current pointer plus the instruction length. The displacement is sign-extended, so a target can lie from 128 bytes before to 127 bytes after that address. All pointer and count arithmetic wraps modulo 2^32.

The loop form decrements first and tests afterwards. A count of one therefore falls through. A count of zero wraps to all ones and keeps the loop running for the full 2^32 iterations. The surrounding core feeds the returned count back into its counter register and the returned pointer into its fetch pointer.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `out_vld`=0, `taken`=0, `nxt_ip`=0 and `cnt_out`=0.
- R2: `out_vld` is high exactly in the cycle after a cycle with `issue` high. When `issue` is low, `nxt_ip`, `cnt_out` and `taken` keep their values.
- R3: Kind code 2'b01 (relative jump) gives `taken`=1, sets `nxt_ip` to `cur_ip`+`ilen`+sext(`rel_off`), and returns `cnt_in` unchanged on `cnt_out`.
- R4: Kind code 2'b10 (counted loop) returns `cnt_out` = `cnt_in` − 1 modulo 2^32.
- R5: A counted loop is taken exactly when `cnt_in` − 1 is nonzero, and its target is computed as in R3.
- R6: A counted loop with `cnt_in`=1 is not taken, gives `nxt_ip` = `cur_ip`+`ilen`, and returns `cnt_out`=0.
- R7: A counted loop with `cnt_in`=0 returns `cnt_out`=32'hFFFF_FFFF and is taken.
- R8: `rel_off` is read as two's complement. 8'h80 reaches 128 bytes back, 8'h7F reaches 127 bytes forward, and 8'hFC reaches 4 bytes back, each measured from `cur_ip`+`ilen`.
- R9: Pointer sums wrap modulo 2^32 in both directions.
- R10: Kind codes 2'b00 and 2'b11 are sequential. They give `taken`=0, `nxt_ip` = `cur_ip`+`ilen`, and return `cnt_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Request strobe; the inputs below are taken in this cycle |
| kind | input | 2 | 00/11 sequential, 01 relative jump, 10 counted loop |
| cur_ip | input | 32 | Address of the branch instruction |
| ilen | input | 4 | Length in bytes of the branch instruction |
| rel_off | input | 8 | Signed displacement from the following instruction |
| cnt_in | input | 32 | Present count register value |
| out_vld | output | 1 | Result valid, one cycle after `issue` |
| nxt_ip | output | 32 | New instruction pointer |
| cnt_out | output | 32 | Count value to write back |
| taken | output | 1 | Branch was taken |

## Verification
In a counted loop, the count decrement and the branch decision happen in the same cycle. The decision must look at the decremented value, not at the incoming one. The bench provokes this with incoming counts of 1, 0 and 2, and with a five-pass loop whose returned count is fed back each step. It judges each result against a bench model that decrements first and then tests. It also checks that the five-pass loop is taken exactly four times and then falls through to the next sequential address.

// File: rtl/brl_pkg.sv
package brl_pkg;

    typedef enum logic [1:0] {
        BK_SEQ  = 2'b00,
        BK_JREL = 2'b01,
        BK_LOOP = 2'b10,
        BK_RSVD = 2'b11
    } brk_kind_e;

    // Branch decision: jumps always go, loops go while the decremented count is nonzero.
    function automatic logic branch_goes(brk_kind_e k, logic dec_nonzero);
        case (k)
            BK_JREL: branch_goes = 1'b1;
            BK_LOOP: branch_goes = dec_nonzero;
            default: branch_goes = 1'b0;
        endcase
    endfunction

    function automatic logic count_updates(brk_kind_e k);
        count_updates = (k == BK_LOOP);
    endfunction

endpackage

// File: rtl/brl_target.sv
module brl_target #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [OFF_W-1:0]  rel_off,
    output logic [ADDR_W-1:0] seq_ip,
    output logic [ADDR_W-1:0] tgt_ip
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam int PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
        seq_ip  = cur_ip + {{PAD_W{1'b0}}, ilen};
        tgt_ip  = seq_ip + off_ext;
    end
endmodule

// File: rtl/brl_count.sv
module brl_count #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_dec,
    output logic             dec_nz
);
    always_comb begin
        cnt_dec = cnt_in - CNT_W'(1);
        dec_nz  = |cnt_dec;
    end
endmodule

// File: rtl/brl_decide.sv
module brl_decide
    import brl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  brk_kind_e         kind,
    input  logic [ADDR_W-1:0] seq_ip,
    input  logic [ADDR_W-1:0] tgt_ip,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [CNT_W-1:0]  cnt_dec,
    input  logic              dec_nz,
    output logic [ADDR_W-1:0] res_ip,
    output logic [CNT_W-1:0]  res_cnt,
    output logic              res_tk
);
    always_comb begin
        res_tk  = branch_goes(kind, dec_nz);
        res_ip  = res_tk ? tgt_ip : seq_ip;
        res_cnt = count_updates(kind) ? cnt_dec : cnt_in;
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import brl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 4,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              out_vld,
    output logic [ADDR_W-1:0] nxt_ip,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              taken
);
    localparam int PAD_W = ADDR_W - LEN_W;

    brk_kind_e         kind_e;
    logic [ADDR_W-1:0] seq_ip, tgt_ip, res_ip;
    logic [CNT_W-1:0]  cnt_dec, res_cnt;
    logic              dec_nz, res_tk;

    assign kind_e = brk_kind_e'(kind);

    brl_target #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_target (
        .cur_ip (cur_ip),
        .ilen   (ilen),
        .rel_off(rel_off),
        .seq_ip (seq_ip),
        .tgt_ip (tgt_ip)
    );

    brl_count #(.CNT_W(CNT_W)) u_count (
        .cnt_in (cnt_in),
        .cnt_dec(cnt_dec),
        .dec_nz (dec_nz)
    );

    brl_decide #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decide (
        .kind   (kind_e),
        .seq_ip (seq_ip),
        .tgt_ip (tgt_ip),
        .cnt_in (cnt_in),
        .cnt_dec(cnt_dec),
        .dec_nz (dec_nz),
        .res_ip (res_ip),
        .res_cnt(res_cnt),
        .res_tk (res_tk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            nxt_ip  <= '0;
            cnt_out <= '0;
            taken   <= 1'b0;
        end else begin
            out_vld <= issue;
            if (issue) begin
                nxt_ip  <= res_ip;
                cnt_out <= res_cnt;
                taken   <= res_tk;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_vld && !taken && nxt_ip == '0 && cnt_out == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) issue |=> out_vld); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !issue |=> ($stable(nxt_ip) && $stable(cnt_out) && $stable(taken))); // R2
    AST_JUMP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst) (issue && kind == 2'b01) |=> (taken && cnt_out == $past(cnt_in))); // R3
    AST_LOOP_DECREMENTS: assert property (@(posedge clk) disable iff (rst) (issue && kind == 2'b10) |=> (cnt_out == $past(cnt_in) - CNT_W'(1))); // R4
    AST_LOOP_LAST_FALLS: assert property (@(posedge clk) disable iff (rst) (issue && kind == 2'b10 && cnt_in == CNT_W'(1)) |=> (!taken && nxt_ip == $past(cur_ip) + {{PAD_W{1'b0}}, $past(ilen)})); // R6
    AST_LOOP_ZERO_WRAPS: assert property (@(posedge clk) disable iff (rst) (issue && kind == 2'b10 && cnt_in == '0) |=> (taken && cnt_out == '1)); // R7
    AST_SEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (issue && (kind == 2'b00 || kind == 2'b11)) |=> (!taken && cnt_out == $past(cnt_in))); // R10

endmodule

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [31:0] cur_ip = '0;
    logic [3:0]  ilen = '0;
    logic [7:0]  rel_off = '0;
    logic [31:0] cnt_in = '0;
    logic        out_vld;
    logic [31:0] nxt_ip;
    logic [31:0] cnt_out;
    logic        taken;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    loop_branch_unit dut_i (
        .clk(clk), .rst(rst), .issue(issue), .kind(kind), .cur_ip(cur_ip),
        .ilen(ilen), .rel_off(rel_off), .cnt_in(cnt_in), .out_vld(out_vld),
        .nxt_ip(nxt_ip), .cnt_out(cnt_out), .taken(taken)
    );

    // Expected {taken, count, pointer} from the requirements.
    function automatic logic [64:0] model(logic [1:0] k, logic [31:0] ip, logic [3:0] len,
                                          logic [7:0] off, logic [31:0] c);
        logic [31:0] seq, tgt, dc;
        seq = ip + {28'b0, len};
        tgt = seq + {{24{off[7]}}, off};
        dc  = c - 32'd1;
        case (k)
            2'b01:   model = {1'b1, c, tgt};
            2'b10:   model = (dc != 0) ? {1'b1, dc, tgt} : {1'b0, dc, seq};
            default: model = {1'b0, c, seq};
        endcase
    endfunction

    task automatic chk(string req, logic [64:0] got, logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Drive one request, sample the result one cycle later.
    task automatic step(string req, logic [1:0] k, logic [31:0] ip, logic [3:0] len,
                        logic [7:0] off, logic [31:0] c);
        kind = k; cur_ip = ip; ilen = len; rel_off = off; cnt_in = c; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        chk({req, " valid"}, {64'b0, out_vld}, 65'd1);
        chk(req, {taken, cnt_out, nxt_ip}, model(k, ip, len, off, c));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [64:0] held;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk("R1 reset", {out_vld, taken, cnt_out, nxt_ip}, 66'b0);
        rst = 1'b0;
        @(negedge clk);

        step("R3 jump fwd", 2'b01, 32'h0000_2000, 4'd2, 8'h10, 32'h0000_0033);
        step("R8 min off", 2'b01, 32'h0000_1000, 4'd2, 8'h80, 32'h0);
        step("R8 max off", 2'b01, 32'h0000_1000, 4'd2, 8'h7F, 32'h0);
        step("R8 minus4", 2'b10, 32'h0000_000C, 4'd2, 8'hFC, 32'd9);
        step("R9 wrap up", 2'b01, 32'hFFFF_FFFE, 4'd2, 8'h05, 32'h0);
        step("R9 wrap down", 2'b10, 32'h0000_0000, 4'd2, 8'h80, 32'd3);
        step("R7 zero count", 2'b10, 32'h0000_0400, 4'd3, 8'hF0, 32'h0);
        step("R6 last pass", 2'b10, 32'h0000_0400, 4'd3, 8'hF0, 32'd1);
        step("R4 loop dec", 2'b10, 32'h0000_0400, 4'd3, 8'hF0, 32'd2);
        step("R10 seq 00", 2'b00, 32'h0000_0500, 4'd5, 8'h40, 32'd77);
        step("R10 seq 11", 2'b11, 32'h0000_0500, 4'd5, 8'h40, 32'd77);

        // R2: outputs hold while idle.
        held = {taken, cnt_out, nxt_ip};
        @(negedge clk);
        chk("R2 valid drops", {64'b0, out_vld}, 65'd0);
        repeat (3) @(negedge clk);
        chk("R2 hold", {taken, cnt_out, nxt_ip}, held);

        // R5: five-pass loop with write-back of the count.
        begin
            logic [31:0] c = 32'd5;
            int tk = 0;
            for (int i = 0; i < 5; i++) begin
                step("R5 loop pass", 2'b10, 32'h0000_0100, 4'd2, 8'hFC, c);
                if (taken) tk++;
                c = cnt_out;
            end
            chk("R5 taken count", {33'b0, 32'(tk)}, 65'd4);
            chk("R5 fall through", {taken, cnt_out, nxt_ip}, {1'b0, 32'd0, 32'h0000_0102});
        end

        for (int i = 0; i < 400; i++) begin
            logic [31:0] c = $urandom;
            if (($urandom % 4) == 0) c = 32'($urandom % 3);
            step("R5 random", 2'($urandom), $urandom, 4'($urandom), 8'($urandom), c);
        end

        summary();
        $finish;
    end
endmodule